// File: doc/BRIEF.md
# Audio DMA Address Generator

This block generates addresses for a single audio DMA channel that runs over a circular buffer. Software programs a start address, an end address (start plus buffer size), a boundary code, a burst code and a threshold code, and then sets the run bit. While running, the engine watches the fill level of its local sample FIFO. When enough entries are free (or, in the capture variant, filled), it issues one burst request on a valid/ready request channel. It then advances its current-address pointer by four bytes for each completed dword. When the pointer reaches the end address it reloads the start address, and the channel keeps running. The pointer can be read at any time, so software can compute the stream position.

A period flag is set each time the pointer lands on an address whose low 5+L bits are all zero, where L is the 4-bit boundary code. The interrupt output is this flag ANDed with an enable bit. The flag is cleared by writing 1 to it.

Back-pressure: once `req_valid` is high it stays high, with `req_addr` and `req_len` stable, until a cycle in which `req_ready` is high. Only one burst is outstanding at a time. Completed dwords are reported on `beat_valid`, one pulse per dword. The engine always accepts these pulses and only counts them while a burst is in flight.

Register word indices on `reg_idx`:
- 0: control, with mask bit 16 and run bit 0.
- 1: start address.
- 2: end address.
- 3: page word, with the boundary code in [7:4]. Bit 11 (translation) is ignored and addressing is always linear.
- 4: configuration, with the burst code in [2:0] and the threshold code in [5:4].
- 5: interrupt enable, bit 0.
- 6: status, with the period flag in bit 0.
- 7: pointer, read-only.

Top module: `audio_dma_agen`

## Requirements
- R1: After reset the run bit, interrupt, request valid and pointer (index 7) all read 0.
- R2: A write to index 0 changes the run bit to wdata[0] only when wdata[16] is 1. A write with bit 16 clear leaves the run bit unchanged.
- R3: A write that turns the run bit from 0 to 1 loads the pointer with the start address, and the first request goes to that address. While the run bit is 0, no new request is raised.
- R4: The request length is 2^B dwords for burst code B (0 gives 1 dword, 7 gives 128 dwords). If fewer dwords remain before the end address, the length is cut to that remainder, so a burst never passes the end address.
- R5: The read-direction engine raises a request only when the free FIFO entries (depth minus `fifo_used`) are at least 1, 4, 8 or 16, for threshold codes 0, 1, 2 and 3.
- R6: Each `beat_valid` during a burst advances the pointer by 4, and index 7 reads the pointer.
- R7: When pointer+4 equals the end address, the pointer reloads the start address, and the next request goes to the start address.
- R8: For boundary code L from 1 to 15, the status flag is set when a step leaves the pointer with its low 5+L bits zero. L=0 never sets it, whatever page bit 11 holds.
- R9: Writing 1 to status bit 0 clears the flag. A boundary event in the same cycle wins.
- R10: `irq` equals the status flag ANDed with enable bit 0 (index 5). With enable 0, `irq` stays low.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_len` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_idx) |
| fifo_used | input | FCW (6) | Valid entries in the local sample FIFO |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted |
| req_addr | output | AW (32) | Burst start byte address |
| req_len | output | 8 | Burst length in dwords |
| req_write | output | 1 | Direction of the request (0 = memory read) |
| beat_valid | input | 1 | One dword of the current burst completed |
| irq | output | 1 | Period interrupt |

## Verification
The bound checker tests the following on every cycle:
- the request hold rule;
- that every request stays inside the buffer with a legal length;
- that each counted beat moves the pointer by exactly four bytes or back to the start address, with the reload forced when the end is reached;
- that the flag only rises on an aligned pointer with a non-zero code;
- that the interrupt stays low while masked;
- that no request appears while stopped.

Only the directed scenarios can show the remaining behaviour:
- the exact request addresses and lengths for each burst code and the cut at the buffer end;
- the threshold gating against concrete FIFO levels;
- the mask-write behaviour of the control word;
- the clearing of the status flag;
- which aligned addresses set the flag for codes 0, 1 and 3.

// File: rtl/adg_pkg.sv
package adg_pkg;

  localparam int LEN_W      = 8;
  localparam int MASK_SHIFT = 16;
  localparam int LIM_BASE   = 5;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_DATA = 2'd2
  } sq_state_t;

  typedef enum logic [2:0] {
    RG_CTRL = 3'd0,
    RG_BASE = 3'd1,
    RG_PROT = 3'd2,
    RG_PAGE = 3'd3,
    RG_CFG  = 3'd4,
    RG_IEN  = 3'd5,
    RG_STAT = 3'd6,
    RG_CUR  = 3'd7
  } reg_idx_t;

  function automatic logic [4:0] thr_dwords(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/adg_regs.sv
module adg_regs
  import adg_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_idx,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [AW-1:0] cur,
  input  logic          flag_set,
  output logic          en,
  output logic          en_rise,
  output logic [AW-1:0] base,
  output logic [AW-1:0] prot,
  output logic [3:0]    lim,
  output logic [2:0]    burst_code,
  output logic [1:0]    thr_code,
  output logic          ien,
  output logic          flag,
  output logic          irq
);

  reg_idx_t sel;
  logic     stat_clr;

  assign sel      = reg_idx_t'(reg_idx);
  assign stat_clr = reg_we && (sel == RG_STAT) && reg_wdata[0];
  assign en_rise  = reg_we && (sel == RG_CTRL) && reg_wdata[MASK_SHIFT]
                    && reg_wdata[0] && !en;
  assign irq      = flag & ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en         <= 1'b0;
      base       <= '0;
      prot       <= '0;
      lim        <= '0;
      burst_code <= '0;
      thr_code   <= '0;
      ien        <= 1'b0;
      flag       <= 1'b0;
    end else begin
      if (reg_we) begin
        case (sel)
          RG_CTRL: if (reg_wdata[MASK_SHIFT]) en <= reg_wdata[0];
          RG_BASE: base <= reg_wdata[AW-1:0];
          RG_PROT: prot <= reg_wdata[AW-1:0];
          RG_PAGE: lim  <= reg_wdata[7:4];
          RG_CFG: begin
            burst_code <= reg_wdata[2:0];
            thr_code   <= reg_wdata[5:4];
          end
          RG_IEN:  ien <= reg_wdata[0];
          default: ;
        endcase
      end
      flag <= flag_set | (flag & ~stat_clr);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RG_CTRL: reg_rdata[0]   = en;
      RG_BASE: reg_rdata      = 32'(base);
      RG_PROT: reg_rdata      = 32'(prot);
      RG_PAGE: reg_rdata[7:4] = lim;
      RG_CFG: begin
        reg_rdata[2:0] = burst_code;
        reg_rdata[5:4] = thr_code;
      end
      RG_IEN:  reg_rdata[0]   = ien;
      RG_STAT: reg_rdata[0]   = flag;
      default: reg_rdata      = 32'(cur);
    endcase
  end

endmodule

// File: rtl/adg_ptr.sv
module adg_ptr
  import adg_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] prot,
  input  logic [3:0]    lim,
  output logic [AW-1:0] cur,
  output logic          hit
);

  logic [AW-1:0] nxt;
  logic [AW-1:0] newv;
  logic [AW-1:0] lmask;

  always_comb begin
    nxt   = cur + AW'(4);
    newv  = (nxt == prot) ? base : nxt;
    lmask = (AW'(1) << (LIM_BASE + int'(lim))) - AW'(1);
    hit   = step && !load && (lim != 4'd0) && ((newv & lmask) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= base;
    else if (step) cur <= newv;
  end

endmodule

// File: rtl/adg_seq.sv
module adg_seq
  import adg_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DEPTH   = 32,
  parameter int FCW     = 6,
  parameter bit CAPTURE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [AW-1:0]    cur,
  input  logic [AW-1:0]    prot,
  input  logic [2:0]       burst_code,
  input  logic [1:0]       thr_code,
  input  logic [FCW-1:0]   fifo_used,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic [LEN_W-1:0] req_len,
  input  logic             beat_valid,
  output logic             step
);

  localparam logic [FCW-1:0] DEPTH_C = FCW'(DEPTH);

  sq_state_t        st;
  logic [AW-1:0]    addr_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] left_q;
  logic [AW-1:0]    rem;
  logic [LEN_W-1:0] blen;
  logic [LEN_W-1:0] len_c;
  logic [FCW-1:0]   thr_w;
  logic             level_ok;

  assign thr_w = FCW'(thr_dwords(thr_code));

  generate
    if (CAPTURE) begin : g_wr
      assign level_ok = fifo_used >= thr_w;
    end else begin : g_rd
      assign level_ok = (DEPTH_C - fifo_used) >= thr_w;
    end
  endgenerate

  always_comb begin
    rem   = (prot - cur) >> 2;
    blen  = LEN_W'(1) << burst_code;
    len_c = (rem < AW'(blen)) ? rem[LEN_W-1:0] : blen;
  end

  assign req_valid = (st == SQ_REQ);
  assign req_addr  = addr_q;
  assign req_len   = len_q;
  assign step      = (st == SQ_DATA) && beat_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      addr_q <= '0;
      len_q  <= '0;
      left_q <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (en && level_ok && (rem != '0)) begin
          st     <= SQ_REQ;
          addr_q <= cur;
          len_q  <= len_c;
        end
        SQ_REQ: if (req_ready) begin
          st     <= SQ_DATA;
          left_q <= len_q;
        end
        SQ_DATA: if (beat_valid) begin
          left_q <= left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/audio_dma_agen.sv
module audio_dma_agen
  import adg_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DEPTH   = 32,
  parameter bit CAPTURE = 1'b0,
  localparam int FCW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_idx,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [FCW-1:0]   fifo_used,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic [LEN_W-1:0] req_len,
  output logic             req_write,
  input  logic             beat_valid,
  output logic             irq
);

  logic          en, en_rise, ien, flag, hit, step;
  logic [AW-1:0] base, prot, cur;
  logic [3:0]    lim;
  logic [2:0]    burst_code;
  logic [1:0]    thr_code;

  assign req_write = CAPTURE;

  adg_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur(cur),
    .flag_set(hit), .en(en), .en_rise(en_rise), .base(base), .prot(prot),
    .lim(lim), .burst_code(burst_code), .thr_code(thr_code), .ien(ien),
    .flag(flag), .irq(irq)
  );

  adg_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(en_rise), .step(step), .base(base),
    .prot(prot), .lim(lim), .cur(cur), .hit(hit)
  );

  adg_seq #(.AW(AW), .DEPTH(DEPTH), .FCW(FCW), .CAPTURE(CAPTURE)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .cur(cur), .prot(prot),
    .burst_code(burst_code), .thr_code(thr_code), .fifo_used(fifo_used),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .beat_valid(beat_valid), .step(step)
  );

endmodule

// File: rtl/adg_chk.sv
module adg_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [7:0]    req_len,
  input logic [AW-1:0] base,
  input logic [AW-1:0] prot,
  input logic [AW-1:0] cur,
  input logic          step,
  input logic [3:0]    lim,
  input logic          flag,
  input logic          ien,
  input logic          irq
);

  function automatic logic [AW-1:0] lmask(input logic [3:0] l);
    return (AW'(1) << (5 + int'(l))) - AW'(1);
  endfunction

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len))); // R11

  AST_BURST_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_len != 8'd0) && (req_len <= 8'd128)
                   && ((req_addr + (AW'(req_len) << 2)) <= prot))); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((cur == $past(cur) + AW'(4)) || (cur == $past(base)))); // R6

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (cur + AW'(4) == prot)) |=> (cur == $past(base))); // R7

  AST_FLAG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ((lim != 4'd0) && ((cur & lmask(lim)) == '0))); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq); // R10

  AST_STOPPED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !req_valid) |=> !req_valid); // R3

endmodule

bind audio_dma_agen adg_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
  .base(base), .prot(prot), .cur(cur), .step(step), .lim(lim),
  .flag(flag), .ien(ien), .irq(irq)
);

// File: tb/audio_dma_agen_tb.sv
`timescale 1ns/100ps
module audio_dma_agen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  fifo_used = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [7:0]  req_len;
  logic        req_write;
  logic        beat_valid = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  audio_dma_agen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_used(fifo_used),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .beat_valid(beat_valid),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] v);
    @(negedge clk);
    reg_idx = i;
    #0.5 v = reg_rdata;
  endtask

  task automatic no_req(input int cycles, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (req_valid) seen = 1'b1;
    end
    chk(tag, {31'b0, seen}, 32'd0);
  endtask

  // Wait for a request, check it, optionally stall, then move len beats.
  task automatic burst(input logic [31:0] a, input int l, input int hold,
                       input bit block, input string tag);
    int w = 0;
    while (!req_valid && w < 300) begin
      @(negedge clk);
      w++;
    end
    chk({tag, " request seen"}, {31'b0, req_valid}, 32'd1);
    chk({tag, " addr"}, req_addr, a);
    chk({tag, " len"}, {24'b0, req_len}, 32'(l));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R11 held request", {req_valid, req_len, req_addr[22:0]},
          {1'b1, 8'(l), a[22:0]});
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    if (block) fifo_used = 6'd32;
    beat_valid = 1'b1;
    for (int i = 0; i < l; i++) @(negedge clk);
    beat_valid = 1'b0;
  endtask

  task automatic reconf(input logic [31:0] b, input logic [31:0] p,
                        input logic [31:0] pg, input logic [31:0] cfg);
    wr(3'd0, 32'h0001_0000);
    wr(3'd1, b);
    wr(3'd2, p);
    wr(3'd3, pg);
    wr(3'd4, cfg);
    wr(3'd6, 32'd1);
    wr(3'd0, 32'h0001_0001);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1 run bit", v, 32'd0);
    rd(3'd7, v); chk("R1 pointer", v, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 req_valid", {31'b0, req_valid}, 32'd0);
  endtask

  task automatic t_main();
    logic [31:0] v;
    wr(3'd1, 32'h0000_1000);
    wr(3'd2, 32'h0000_1100);
    wr(3'd3, 32'h0000_0010);          // code 1: 64-byte periods
    wr(3'd4, 32'h0000_0003);          // 8 dwords, threshold 1
    no_req(5, "R3 stopped no request");
    wr(3'd0, 32'h0001_0001);
    rd(3'd7, v); chk("R3 pointer loaded", v, 32'h1000);
    burst(32'h1000, 8, 0, 0, "R3 R4 first burst");
    rd(3'd7, v); chk("R6 pointer after 8 beats", v, 32'h1020);
    rd(3'd6, v); chk("R8 no flag at 0x1020", v, 32'd0);
    burst(32'h1020, 8, 0, 0, "R4 second burst");
    rd(3'd6, v); chk("R8 flag at 0x1040", v, 32'd1);
    chk("R10 irq masked", {31'b0, irq}, 32'd0);
    wr(3'd5, 32'd1);
    chk("R10 irq enabled", {31'b0, irq}, 32'd1);
    wr(3'd6, 32'd1);
    rd(3'd6, v); chk("R9 flag cleared", v, 32'd0);
    chk("R10 irq after clear", {31'b0, irq}, 32'd0);
    wr(3'd0, 32'h0000_0000);
    rd(3'd0, v); chk("R2 unmasked write ignored", v, 32'd1);
    for (int k = 0; k < 6; k++)
      burst(32'h1040 + 32'(k) * 32'h20, 8, 0, 0, "R6 stream");
    rd(3'd7, v); chk("R7 pointer wrapped", v, 32'h1000);
    burst(32'h1000, 8, 0, 1, "R7 request after wrap");
    rd(3'd7, v); chk("R6 pointer after wrap burst", v, 32'h1020);
    no_req(10, "R5 full fifo blocks");
  endtask

  task automatic t_threshold();
    wr(3'd4, 32'h0000_0033);          // 8 dwords, threshold 16
    fifo_used = 6'd17;
    no_req(10, "R5 15 free below 16");
    fifo_used = 6'd16;
    burst(32'h1020, 8, 0, 1, "R5 16 free");
  endtask

  task automatic t_cap();
    logic [31:0] v;
    wr(3'd0, 32'h0001_0000);
    rd(3'd0, v); chk("R2 masked clear", v, 32'd0);
    fifo_used = 6'd0;
    no_req(5, "R3 stopped no request");
    // code 0 with bit 11 set: linear, no flag
    reconf(32'h2000, 32'h2030, 32'h0000_0800, 32'h0000_0003);
    rd(3'd7, v); chk("R3 reload base", v, 32'h2000);
    burst(32'h2000, 8, 0, 0, "R4 full burst");
    burst(32'h2020, 4, 0, 1, "R4 cut at end");
    rd(3'd7, v); chk("R7 wrap short buffer", v, 32'h2000);
    rd(3'd6, v); chk("R8 code 0 no flag", v, 32'd0);
  endtask

  task automatic t_long();
    logic [31:0] v;
    reconf(32'h3000, 32'h3100, 32'h0000_0030, 32'h0000_0005);  // code 3, 32 dwords
    fifo_used = 6'd0;
    burst(32'h3000, 32, 0, 0, "R4 32-dword burst");
    rd(3'd6, v); chk("R8 code 3 no flag at 0x3080", v, 32'd0);
    burst(32'h3080, 32, 0, 1, "R4 second 32-dword burst");
    rd(3'd6, v); chk("R8 code 3 flag at wrap 0x3000", v, 32'd1);
    chk("R10 irq follows flag", {31'b0, irq}, 32'd1);
    reconf(32'h4000, 32'h4400, 32'h0000_0030, 32'h0000_0007);
    fifo_used = 6'd0;
    burst(32'h4000, 128, 5, 1, "R4 R11 128-dword burst");
    rd(3'd7, v); chk("R6 pointer after 128", v, 32'h4200);
    rd(3'd6, v); chk("R8 flag at 0x4200", v, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_main();
    t_threshold();
    t_cap();
    t_long();
    chk("R5 read direction", {31'b0, req_write}, 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule